// File: doc/BRIEF.md
# Floppy Read-ID Command Sequencer

This block carries out the read-identifier command of a floppy disk controller once the command bytes have been decoded elsewhere. A start strobe arrives together with the drive/head select byte. The sequencer then waits for a separate data separator to report an ID address mark. The four ID bytes that follow the mark are stored as cylinder, head, sector and size.

The timeout is not a cycle count. The sequencer counts disk index pulses, and a pulse counts only if it stays high long enough. The internal clock period is derived from the oscillator clock according to the selected data rate. If the second qualified index pulse arrives before any ID address mark, the command ends abnormally. In both cases the block builds status bytes 0 and 1, drops its busy flag and gives a one-cycle interrupt pulse. The status bytes and the four ID bytes then form the result phase.

Top module: `fdc_readid_seq`

## Requirements
- R1: After reset, busy and irq are 0 and every result output (st0, st1, cylinder, head, sector, size) is 0.
- R2: A cmd_start pulse while idle raises busy on the next cycle. Busy stays high until completion. A cmd_start pulse while busy is ignored, so its select byte does not appear in the result.
- R3: The drive number is taken from bits 1:0 of the select byte and the head from bit 2. Status byte 0 reports the drive in bits 1:0 and the head in bit 2, with bits 5:3 always 0.
- R4: After an ID address mark, the next four byte strobes are stored in order as cylinder, head, sector and size. On this success path st0[7:6] is 00 and st1 is 0x00.
- R5: If the second qualified index pulse after start arrives with no ID address mark yet seen, the command ends with st0[7:6] = 01 and st1 = 0x01 (bit 0 is the missing-mark flag). The four ID outputs read 0.
- R6: A single qualified index pulse does not end the command.
- R7: An index pulse is counted only if it stays high for at least 5 internal clock periods. Shorter pulses are ignored.
- R8: One internal clock period lasts 6, 10, 12 or 3 oscillator cycles for rate select 0, 1, 2 or 3 respectively (0 = 500 kbps, 3 = 1 Mbps).
- R9: The irq output is high for exactly one cycle. That cycle is the first one with busy low after the command.
- R10: Byte strobes that arrive before the ID address mark are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle command start strobe |
| cmd_sel | input | 8 | Drive/head select byte of the command |
| rate_sel | input | 2 | Data-rate select |
| index_raw | input | 1 | Asynchronous disk index pulse |
| id_mark | input | 1 | ID address mark found (one cycle) |
| id_strobe | input | 1 | ID byte valid |
| id_byte | input | 8 | ID byte from the data separator |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Completion pulse |
| st0 | output | 8 | Status byte 0 |
| st1 | output | 8 | Status byte 1 |
| res_cyl | output | 8 | Captured cylinder |
| res_head | output | 8 | Captured head |
| res_sect | output | 8 | Captured sector |
| res_size | output | 8 | Captured size code |

## Verification
The assertions check the handshake on every cycle. Busy may only rise after a start strobe, and it can only end through the completion pulse. The pulse itself lasts one cycle with busy low. The status encodings must also stay consistent with each other: an abnormal code comes with the missing-mark flag and zeroed ID bytes, and a normal code comes with a clear st1. Only the bench scenarios can show the width qualification of index pulses and its dependence on the rate select. The same holds for the two-pulse timeout, the order in which bytes are captured and the rejection of strobes that arrive early.

// File: rtl/fdc_rid_pkg.sv
package fdc_rid_pkg;
  typedef enum logic [1:0] {
    RID_IDLE  = 2'd0,
    RID_HUNT  = 2'd1,
    RID_FIELD = 2'd2,
    RID_DONE  = 2'd3
  } rid_state_e;

  localparam int DIV_W = 4;

  // oscillator cycles per internal clock period for each rate code
  function automatic logic [DIV_W-1:0] rate_div(input logic [1:0] rate);
    case (rate)
      2'd0:    rate_div = 4'd6;
      2'd1:    rate_div = 4'd10;
      2'd2:    rate_div = 4'd12;
      default: rate_div = 4'd3;
    endcase
  endfunction
endpackage

// File: rtl/rid_tick_gen.sv
module rid_tick_gen
  import fdc_rid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim  = rate_div(rate_sel) - 4'd1;
    tick = (cnt_q >= lim);
    cnt_d = tick ? '0 : cnt_q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rid_index_qual.sv
module rid_index_qual #(
  parameter int QUAL_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic index_raw,
  output logic idx_qual
);
  localparam int WW = $clog2(QUAL_TICKS + 1);
  localparam logic [WW-1:0] W_LAST = WW'(QUAL_TICKS - 1);
  localparam logic [WW-1:0] W_FULL = WW'(QUAL_TICKS);

  logic [1:0]    sync_q;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          lvl;

  assign lvl = sync_q[1];

  always_comb begin
    wcnt_d = wcnt_q;
    if (!lvl)                         wcnt_d = '0;
    else if (tick && wcnt_q != W_FULL) wcnt_d = wcnt_q + 1'b1;
    idx_qual = lvl && tick && (wcnt_q == W_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      wcnt_q <= '0;
    end else begin
      sync_q <= {sync_q[0], index_raw};
      wcnt_q <= wcnt_d;
    end
  end
endmodule

// File: rtl/fdc_readid_seq.sv
module fdc_readid_seq
  import fdc_rid_pkg::*;
#(
  parameter int QUAL_TICKS     = 5,
  parameter int TIMEOUT_PULSES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic [7:0] cmd_sel,
  input  logic [1:0] rate_sel,
  input  logic       index_raw,
  input  logic       id_mark,
  input  logic       id_strobe,
  input  logic [7:0] id_byte,
  output logic       busy,
  output logic       irq,
  output logic [7:0] st0,
  output logic [7:0] st1,
  output logic [7:0] res_cyl,
  output logic [7:0] res_head,
  output logic [7:0] res_sect,
  output logic [7:0] res_size
);
  localparam int ID_BYTES = 4;
  localparam int BW = $clog2(ID_BYTES);
  localparam int IW = $clog2(TIMEOUT_PULSES + 1);
  localparam logic [BW-1:0] B_LAST = BW'(ID_BYTES - 1);
  localparam logic [IW-1:0] I_LAST = IW'(TIMEOUT_PULSES - 1);

  logic tick, idx_qual;

  rid_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tick(tick)
  );

  rid_index_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick), .index_raw(index_raw), .idx_qual(idx_qual)
  );

  rid_state_e                 state_q, state_d;
  logic [1:0]                 drv_q, drv_d;
  logic                       hd_q, hd_d;
  logic [IW-1:0]              icnt_q, icnt_d;
  logic [BW-1:0]              bidx_q, bidx_d;
  logic [ID_BYTES-1:0][7:0]   id_q, id_d;
  logic [7:0]                 st0_q, st0_d, st1_q, st1_d;

  always_comb begin
    state_d = state_q;
    drv_d   = drv_q;
    hd_d    = hd_q;
    icnt_d  = icnt_q;
    bidx_d  = bidx_q;
    id_d    = id_q;
    st0_d   = st0_q;
    st1_d   = st1_q;
    case (state_q)
      RID_IDLE: begin
        if (cmd_start) begin
          state_d = RID_HUNT;
          drv_d   = cmd_sel[1:0];
          hd_d    = cmd_sel[2];
          icnt_d  = '0;
          bidx_d  = '0;
          id_d    = '0;
          st0_d   = '0;
          st1_d   = '0;
        end
      end
      RID_HUNT: begin
        // a mark in the same cycle as the expiring pulse wins
        if (id_mark) begin
          state_d = RID_FIELD;
        end else if (idx_qual) begin
          if (icnt_q == I_LAST) begin
            state_d = RID_DONE;
            st0_d   = {2'b01, 3'b000, hd_q, drv_q};
            st1_d   = 8'h01;
          end else begin
            icnt_d = icnt_q + 1'b1;
          end
        end
      end
      RID_FIELD: begin
        if (id_strobe) begin
          id_d[bidx_q] = id_byte;
          bidx_d       = bidx_q + 1'b1;
          if (bidx_q == B_LAST) begin
            state_d = RID_DONE;
            st0_d   = {2'b00, 3'b000, hd_q, drv_q};
            st1_d   = 8'h00;
          end
        end
      end
      default: state_d = RID_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RID_IDLE;
      drv_q   <= '0;
      hd_q    <= 1'b0;
      icnt_q  <= '0;
      bidx_q  <= '0;
      id_q    <= '0;
      st0_q   <= '0;
      st1_q   <= '0;
    end else begin
      state_q <= state_d;
      drv_q   <= drv_d;
      hd_q    <= hd_d;
      icnt_q  <= icnt_d;
      bidx_q  <= bidx_d;
      id_q    <= id_d;
      st0_q   <= st0_d;
      st1_q   <= st1_d;
    end
  end

  assign busy     = (state_q == RID_HUNT) || (state_q == RID_FIELD);
  assign irq      = (state_q == RID_DONE);
  assign st0      = st0_q;
  assign st1      = st1_q;
  assign res_cyl  = id_q[0];
  assign res_head = id_q[1];
  assign res_sect = id_q[2];
  assign res_size = id_q[3];
endmodule

// File: rtl/fdc_readid_chk.sv
module fdc_readid_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic       busy,
  input logic       irq,
  input logic [7:0] st0,
  input logic [7:0] st1,
  input logic [7:0] res_cyl,
  input logic [7:0] res_head,
  input logic [7:0] res_sect,
  input logic [7:0] res_size
);
  a_r9_irq_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r9_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(busy));

  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_start));

  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || irq));

  a_r3_st0_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st0[5:3] == 3'b000 && !st0[7]));

  a_r5_abort_status: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && st0[7:6] == 2'b01) |->
      (st1 == 8'h01 && res_cyl == 8'h00 && res_head == 8'h00 &&
       res_sect == 8'h00 && res_size == 8'h00));

  a_r4_ok_status: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && st0[7:6] == 2'b00) |-> (st1 == 8'h00));
endmodule

bind fdc_readid_seq fdc_readid_chk u_chk (.*);

// File: tb/fdc_readid_seq_bench.sv
module fdc_readid_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0;
  logic [7:0] cmd_sel = 8'h00;
  logic [1:0] rate_sel = 2'd0;
  logic       index_raw = 1'b0;
  logic       id_mark = 1'b0;
  logic       id_strobe = 1'b0;
  logic [7:0] id_byte = 8'h00;
  logic       busy, irq;
  logic [7:0] st0, st1, res_cyl, res_head, res_sect, res_size;

  int checks = 0;
  int failures = 0;
  int irq_cnt = 0;
  logic       snap_busy;
  logic [7:0] snap[6];
  bit done = 0;

  always #2.5 clk = ~clk;

  fdc_readid_seq u_fdc_readid_seq (.*);

  always @(negedge clk) begin
    if (irq) begin
      irq_cnt  <= irq_cnt + 1;
      snap_busy <= busy;
      snap[0] <= st0; snap[1] <= st1; snap[2] <= res_cyl;
      snap[3] <= res_head; snap[4] <= res_sect; snap[5] <= res_size;
    end
  end

  function automatic int div_of(input logic [1:0] r);
    case (r)
      2'd0: return 6;
      2'd1: return 10;
      2'd2: return 12;
      default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] exp_st0(input bit abort, input logic [7:0] sel);
    return {1'b0, abort, 3'b000, sel[2], sel[1:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_cmd(input logic [7:0] sel);
    @(negedge clk); cmd_sel = sel; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic pulse(input int len);
    @(negedge clk); index_raw = 1'b1;
    repeat (len) @(negedge clk);
    index_raw = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic valid_pulse();
    pulse(8 * div_of(rate_sel));
  endtask

  task automatic short_pulse();
    pulse(3 * div_of(rate_sel));
  endtask

  task automatic send_id(input logic [7:0] b[4]);
    @(negedge clk); id_mark = 1'b1;
    @(negedge clk); id_mark = 1'b0;
    for (int i = 0; i < 4; i++) begin
      repeat ($urandom_range(3, 0)) @(negedge clk);
      id_strobe = 1'b1; id_byte = b[i];
      @(negedge clk); id_strobe = 1'b0; id_byte = $urandom;
    end
  endtask

  task automatic junk_strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); id_strobe = 1'b1; id_byte = 8'hEE;
      @(negedge clk); id_strobe = 1'b0;
    end
  endtask

  task automatic wait_irq(input int base, input string req);
    for (int i = 0; i < 3000 && irq_cnt == base; i++) begin
      @(negedge clk); #1;
    end
    check({req, " irq seen"}, (irq_cnt == base + 1), 1);
  endtask

  task automatic check_result(input string req, input bit abort, input logic [7:0] sel,
                              input logic [7:0] b[4]);
    check({req, " busy low at irq (R9)"}, snap_busy, 0);
    check({req, " st0 (R3)"}, snap[0], exp_st0(abort, sel));
    check({req, " st1"}, snap[1], abort ? 8'h01 : 8'h00);
    for (int i = 0; i < 4; i++)
      check({req, " id byte"}, snap[2+i], abort ? 8'h00 : b[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] b[4];
    logic [7:0] sel;
    int base;
    void'($urandom(32'h5eed));

    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 irq", irq, 0);
    check("R1 st0", st0, 0);
    check("R1 st1", st1, 0);
    check("R1 ids", {res_cyl, res_head, res_sect, res_size}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed success, drive 1 head 1, plus ignored restart and early strobes
    rate_sel = 2'd0;
    base = irq_cnt;
    b = '{8'h12, 8'h01, 8'h07, 8'h02};
    start_cmd(8'h05);
    check("R2 busy after start", busy, 1);
    @(negedge clk); cmd_sel = 8'h02; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    junk_strobes(3);                 // R10
    check("R2 still busy", busy, 1);
    send_id(b);
    wait_irq(base, "R4");
    check_result("R4/R2/R10", 0, 8'h05, b);
    @(negedge clk); #1;
    check("R9 irq one cycle", irq, 0);

    // abort: one pulse is not enough, two are
    base = irq_cnt;
    start_cmd(8'h06);
    valid_pulse();
    repeat (40) @(negedge clk);
    check("R6 one pulse no irq", irq_cnt, base);
    check("R6 still busy", busy, 1);
    valid_pulse();
    wait_irq(base, "R5");
    check_result("R5", 1, 8'h06, b);

    // short pulses ignored
    base = irq_cnt;
    start_cmd(8'h03);
    valid_pulse();
    short_pulse(); short_pulse();
    repeat (20) @(negedge clk);
    check("R7 short pulse ignored", busy, 1);
    valid_pulse();
    wait_irq(base, "R7");
    check_result("R7", 1, 8'h03, b);

    // rate dependence: 20-cycle pulse counts at rate 3, not at rate 2
    rate_sel = 2'd3;
    base = irq_cnt;
    start_cmd(8'h00);
    pulse(20); pulse(20);
    wait_irq(base, "R8 fast rate");
    check_result("R8", 1, 8'h00, b);

    rate_sel = 2'd2;
    base = irq_cnt;
    start_cmd(8'h01);
    valid_pulse();
    pulse(20);
    repeat (20) @(negedge clk);
    check("R8 slow rate ignores 20-cycle pulse", busy, 1);
    b = '{8'h4F, 8'h00, 8'h12, 8'h03};
    send_id(b);
    wait_irq(base, "R8 slow");
    check_result("R8", 0, 8'h01, b);

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      bit ab;
      rate_sel = 2'($urandom_range(3, 0));
      sel = 8'($urandom);
      ab = ($urandom_range(1, 0) == 1);
      for (int k = 0; k < 4; k++) b[k] = 8'($urandom);
      base = irq_cnt;
      start_cmd(sel);
      if ($urandom_range(1, 0) == 1) junk_strobes(2);
      if ($urandom_range(1, 0) == 1) short_pulse();
      if (ab) begin
        valid_pulse();
        if ($urandom_range(1, 0) == 1) short_pulse();
        valid_pulse();
      end else begin
        if ($urandom_range(1, 0) == 1) valid_pulse();
        send_id(b);
      end
      wait_irq(base, ab ? "R5 rand" : "R4 rand");
      check_result(ab ? "R5 rand" : "R4 rand", ab, sel, b);
      repeat (4) @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule